// File: doc/BRIEF.md
# Sample-Gated Fault Status Register

This block holds the fault state of a sampled sensor interface. Eight independent fault sources enter as plain level bits. Each source first passes through a fixed detection delay. After that delay it sets its own sticky bit in a fault register. Two active-low group indicators report whether any bit in their group is set. Bits 3:0 form group A and bits 7:4 form group B.

A sample strobe, idle high, manages the register in two steps. A falling edge that follows no fault read takes a snapshot of the register. The host reads that snapshot over an 8-bit parallel port in configuration mode. The next falling edge after such a read clears only the bits that the snapshot reported. Bits set after the snapshot stay pending. Bits whose source is still active stay set, so no fault event is lost between capture and readout.

The port is in configuration mode when the two-bit mode selector is 2'b11. Addresses and data share one 8-bit write bus. The selected register address survives leaving and re-entering configuration mode, so a host that selects the fault address once can then poll it by toggling the mode pins.

Top module: `fault_latch_unit`

## Requirements
- R1: After reset the fault register and snapshot are zero, both indicators are high, bus_out is zero, and the selected address is RESET_ADDR (default 8'h80). RESET_ADDR is not the fault address, so a read returns zero.
- R2: A fault input sampled high at a rising clock edge sets its register bit exactly LATENCY edges later (default 4). The bit then stays set whatever the input does, until a clearing sample edge.
- R3: grp_a_n is low exactly when any of register bits 3:0 is set. grp_b_n is low exactly when any of bits 7:4 is set.
- R4: Configuration mode is mode_sel == 2'b11. In any other mode, writes leave the address unchanged and reads return zero.
- R5: An address write happens on a clock edge where all of these hold: configuration mode, cs_n low, wr_n low, rd_n high, and bus_in[7] = 1. The address register then loads bus_in. A write with rd_n low or with bus_in[7] = 0 is ignored.
- R6: The selected address is kept unchanged while configuration mode is left and entered again.
- R7: A fault read requires configuration mode, cs_n low, rd_n low, wr_n high, and selected address FAULT_ADDR (default 8'hFF). During a fault read, bus_out shows the snapshot, zero-extended, in the same cycle. Otherwise bus_out is zero, including whenever cs_n is high.
- R8: Reading the snapshot clears neither the fault register nor the indicators.
- R9: A sample falling edge is sample high at one rising clock edge and low at the next. If no fault read has occurred since the previous falling edge, the edge loads the snapshot with the register and clears nothing.
- R10: A falling edge that follows a fault read clears the bits set in the snapshot. It keeps bits set after the snapshot was taken. A bit whose source was high LATENCY edges earlier is set again at once. The snapshot is then reloaded with the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fault_in | input | 8 | Fault source levels, one per register bit |
| sample | input | 1 | Sample strobe, idle high; falling edge captures or clears |
| mode_sel | input | 2 | Mode selector; 2'b11 is configuration mode |
| cs_n | input | 1 | Active-low chip select for the parallel port |
| rd_n | input | 1 | Active-low read enable |
| wr_n | input | 1 | Active-low write enable |
| bus_in | input | 8 | Shared address/data write bus |
| bus_out | output | 8 | Read data; zero when no fault read is active |
| grp_a_n | output | 1 | Active-low indicator for fault bits 3:0 |
| grp_b_n | output | 1 | Active-low indicator for fault bits 7:4 |

## Verification
On every cycle, the assertions check the following. Fault bits only drop on a sample falling edge. The snapshot changes only on such an edge and then equals the register. The snapshot never holds a bit the register lacks. A set snapshot bit keeps its group indicator low. The address holds when no qualifying write occurs. The read bus is zero whenever chip select is high. Other behaviour needs the bench's scenarios with a running reference model. That covers the exact detection latency, and that a read never clears anything. It also covers the selective clear that keeps pending and persistent faults, and address persistence across mode changes. Finally, it covers the ignored write forms.

// File: rtl/fault_latch_pkg.sv
package fault_latch_pkg;
  localparam int unsigned NFAULT = 8;
  localparam int unsigned BUSW   = 8;
  localparam logic [1:0]  SEL_CFG = 2'b11;
  typedef logic [NFAULT-1:0] fvec_t;
  typedef logic [BUSW-1:0]   bus_t;
endpackage

// File: rtl/fault_delay_line.sv
module fault_delay_line #(
  parameter int unsigned W   = 8,
  parameter int unsigned LAT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (LAT == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] stg_q [LAT];
      for (genvar g = 0; g < LAT; g++) begin : g_stage
        logic [W-1:0] stg_d;
        if (g == 0) begin : g_head
          assign stg_d = din;
        end else begin : g_tail
          assign stg_d = stg_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= '0;
          else        stg_q[g] <= stg_d;
        end
      end
      assign dout = stg_q[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/fault_sticky_core.sv
module fault_sticky_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] det,
  input  logic         sample,
  input  logic         rd_hit,
  output logic [W-1:0] flt_q,
  output logic [W-1:0] snap_q,
  output logic         smp_fall
);
  logic         smp_q;
  logic         seen_q, seen_d;
  logic [W-1:0] flt_d, snap_d;
  logic         snap_en;

  always_comb begin
    smp_fall = smp_q & ~sample;
    flt_d    = flt_q | det;
    if (smp_fall && seen_q) flt_d = (flt_q & ~snap_q) | det;
    snap_en  = smp_fall;
    snap_d   = flt_d;
    seen_d   = smp_fall ? 1'b0 : (seen_q | rd_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b1;
      seen_q <= 1'b0;
      flt_q  <= '0;
      snap_q <= '0;
    end else begin
      smp_q  <= sample;
      seen_q <= seen_d;
      flt_q  <= flt_d;
      if (snap_en) snap_q <= snap_d;
    end
  end
endmodule

// File: rtl/fault_host_port.sv
module fault_host_port
  import fault_latch_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter bus_t        RST_ADDR = 8'h80,
  parameter bus_t        FLT_ADDR = 8'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  bus_t         bus_in,
  input  logic [W-1:0] snap,
  output bus_t         bus_out,
  output logic         rd_hit,
  output logic         wr_hit,
  output bus_t         addr_q
);
  logic cfg;
  bus_t addr_d;

  always_comb begin
    cfg     = (mode_sel == SEL_CFG);
    wr_hit  = cfg & ~cs_n & ~wr_n & rd_n & bus_in[BUSW-1];
    rd_hit  = cfg & ~cs_n & ~rd_n & wr_n & (addr_q == FLT_ADDR);
    bus_out = rd_hit ? BUSW'(snap) : '0;
    addr_d  = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= RST_ADDR;
    else if (wr_hit) addr_q <= addr_d;
  end
endmodule

// File: rtl/fault_latch_unit.sv
module fault_latch_unit
  import fault_latch_pkg::*;
#(
  parameter int unsigned LATENCY    = 4,
  parameter fvec_t       GRP_A_MASK = 8'h0F,
  parameter fvec_t       GRP_B_MASK = 8'hF0,
  parameter bus_t        RESET_ADDR = 8'h80,
  parameter bus_t        FAULT_ADDR = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  fvec_t       fault_in,
  input  logic        sample,
  input  logic [1:0]  mode_sel,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  bus_t        bus_in,
  output bus_t        bus_out,
  output logic        grp_a_n,
  output logic        grp_b_n
);
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  fvec_t      det, flt_q, snap_q;
  logic       smp_fall, rd_hit, wr_hit;
  bus_t       addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  fault_delay_line #(.W(NFAULT), .LAT(LATENCY)) u_dly (
    .clk(clk), .rst_n(rst_sync_n), .din(fault_in), .dout(det)
  );

  fault_sticky_core #(.W(NFAULT)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .det(det), .sample(sample),
    .rd_hit(rd_hit), .flt_q(flt_q), .snap_q(snap_q), .smp_fall(smp_fall)
  );

  fault_host_port #(.W(NFAULT), .RST_ADDR(RESET_ADDR), .FLT_ADDR(FAULT_ADDR)) u_port (
    .clk(clk), .rst_n(rst_sync_n), .mode_sel(mode_sel), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in), .snap(snap_q),
    .bus_out(bus_out), .rd_hit(rd_hit), .wr_hit(wr_hit), .addr_q(addr_q)
  );

  assign grp_a_n = ~|(flt_q & GRP_A_MASK);
  assign grp_b_n = ~|(flt_q & GRP_B_MASK);
endmodule

// File: rtl/fault_latch_unit_chk.sv
module fault_latch_unit_chk
  import fault_latch_pkg::*;
#(
  parameter fvec_t MA = 8'h0F,
  parameter fvec_t MB = 8'hF0
) (
  input logic  clk,
  input logic  rst_sync_n,
  input logic  cs_n,
  input bus_t  bus_out,
  input logic  grp_a_n,
  input logic  grp_b_n,
  input fvec_t flt_q,
  input fvec_t snap_q,
  input bus_t  addr_q,
  input logic  smp_fall,
  input logic  wr_hit
);
  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !smp_fall |=> ((flt_q & $past(flt_q)) == $past(flt_q))); // R2
  AST_SNAP_IND_A: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(snap_q & MA)) |-> !grp_a_n); // R3
  AST_SNAP_IND_B: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(snap_q & MB)) |-> !grp_b_n); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_hit |=> $stable(addr_q)); // R6
  AST_CS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_n |-> (bus_out == '0)); // R7
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !smp_fall |=> $stable(snap_q)); // R8
  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    smp_fall |=> (snap_q == flt_q)); // R9
  AST_SNAP_SUBSET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((snap_q & ~flt_q) == '0)); // R10
endmodule

bind fault_latch_unit fault_latch_unit_chk #(.MA(GRP_A_MASK), .MB(GRP_B_MASK)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cs_n(cs_n), .bus_out(bus_out),
  .grp_a_n(grp_a_n), .grp_b_n(grp_b_n), .flt_q(flt_q), .snap_q(snap_q),
  .addr_q(addr_q), .smp_fall(smp_fall), .wr_hit(wr_hit)
);

// File: tb/fault_latch_unit_test.sv
`timescale 1ns/1ps
module fault_latch_unit_test;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] fault_in, bus_in, bus_out;
  logic       sample, cs_n, rd_n, wr_n, grp_a_n, grp_b_n;
  logic [1:0] mode_sel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fault_latch_unit uut (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .sample(sample),
    .mode_sel(mode_sel), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .grp_a_n(grp_a_n), .grp_b_n(grp_b_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [7:0] m_flt, m_snap, m_addr;
  bit         m_seen, m_smp;
  logic [7:0] dq[$];

  function automatic bit m_cfg();
    return mode_sel == 2'b11;
  endfunction
  function automatic bit m_rd();
    return m_cfg() && !cs_n && !rd_n && wr_n && (m_addr == 8'hFF);
  endfunction
  function automatic bit m_wr();
    return m_cfg() && !cs_n && !wr_n && rd_n && bus_in[7];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flt = 8'h00; m_snap = 8'h00; m_addr = 8'h80; m_seen = 0; m_smp = 1;
      dq = {};
      for (int i = 0; i < LAT; i++) dq.push_back(8'h00);
    end else begin
      logic [7:0] det;
      bit fall;
      det = dq.pop_front();
      dq.push_back(fault_in);
      fall = m_smp && !sample;
      if (fall && m_seen) m_flt = (m_flt & ~m_snap) | det;
      else                m_flt = m_flt | det;
      if (fall) begin
        m_snap = m_flt;
        m_seen = 0;
      end else if (m_rd()) m_seen = 1;
      if (m_wr()) m_addr = bus_in;
      m_smp = sample;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(grp_a_n == ~|(m_flt & 8'h0F), "R3 model group A", {7'd0, grp_a_n}, {7'd0, ~|(m_flt & 8'h0F)});
      chk(grp_b_n == ~|(m_flt & 8'hF0), "R3 model group B", {7'd0, grp_b_n}, {7'd0, ~|(m_flt & 8'hF0)});
      chk(bus_out == (m_rd() ? m_snap : 8'h00), "R7 model read bus", bus_out, m_rd() ? m_snap : 8'h00);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask
  task automatic idle_bus();
    cs_n = 1; rd_n = 1; wr_n = 1; bus_in = 8'h00;
  endtask
  task automatic cfg_write(input logic [7:0] v);
    mode_sel = 2'b11; cs_n = 0; wr_n = 0; rd_n = 1; bus_in = v;
    tick();
    idle_bus();
  endtask
  task automatic cfg_read(output logic [7:0] v);
    mode_sel = 2'b11; cs_n = 0; rd_n = 0; wr_n = 1;
    #1 v = bus_out;
    tick();
    idle_bus();
  endtask
  task automatic strobe();
    sample = 0; tick();
    sample = 1; tick();
  endtask
  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0t expected=finish", $time);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 0; fault_in = 0; sample = 1; mode_sel = 2'b00; idle_bus();
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    // R1 reset state
    chk(grp_a_n === 1'b1, "R1 reset grp_a_n", {7'd0, grp_a_n}, 8'h01);
    chk(grp_b_n === 1'b1, "R1 reset grp_b_n", {7'd0, grp_b_n}, 8'h01);
    chk(bus_out === 8'h00, "R1 reset bus_out", bus_out, 8'h00);
    cfg_read(v);
    chk(v === 8'h00, "R1 default address not fault address", v, 8'h00);
    mode_sel = 2'b00;

    // R2 latency: bit0 persistent, bit1 single-cycle pulse
    fault_in = 8'h03; tick();
    fault_in = 8'h01; tick(); tick(); tick();
    chk(grp_a_n === 1'b1, "R2 not yet set before latency", {7'd0, grp_a_n}, 8'h01);
    tick();
    chk(grp_a_n === 1'b0, "R2 set after latency", {7'd0, grp_a_n}, 8'h00);
    chk(grp_b_n === 1'b1, "R3 group B untouched", {7'd0, grp_b_n}, 8'h01);

    // select fault address, capture
    cfg_write(8'hFF);
    mode_sel = 2'b00;
    strobe();
    chk(grp_a_n === 1'b0, "R9 capture clears nothing", {7'd0, grp_a_n}, 8'h00);

    // pending fault after capture
    fault_in = 8'h21; tick();
    fault_in = 8'h01;
    repeat (5) tick();
    chk(grp_b_n === 1'b0, "R3 group B from bit5", {7'd0, grp_b_n}, 8'h00);

    cfg_read(v);
    chk(v === 8'h03, "R9 snapshot excludes later fault", v, 8'h03);
    cfg_read(v);
    chk(v === 8'h03, "R8 second read unchanged", v, 8'h03);
    chk(grp_a_n === 1'b0, "R8 read leaves indicator", {7'd0, grp_a_n}, 8'h00);

    mode_sel = 2'b11; cs_n = 1; rd_n = 0; wr_n = 1;
    #1 chk(bus_out === 8'h00, "R7 cs_n high gives zero", bus_out, 8'h00);
    tick(); idle_bus();

    mode_sel = 2'b00;
    strobe();
    chk(grp_b_n === 1'b0, "R10 pending bit5 kept", {7'd0, grp_b_n}, 8'h00);
    chk(grp_a_n === 1'b0, "R10 persistent bit0 kept", {7'd0, grp_a_n}, 8'h00);

    fault_in = 8'h00;
    repeat (6) tick();
    cfg_read(v);
    chk(v === 8'h21, "R6 address kept across mode exit", v, 8'h21);
    mode_sel = 2'b00;
    strobe();
    chk(grp_a_n === 1'b1, "R10 clear group A", {7'd0, grp_a_n}, 8'h01);
    chk(grp_b_n === 1'b1, "R10 clear group B", {7'd0, grp_b_n}, 8'h01);

    // new fault bit7, capture without read
    fault_in = 8'h80; tick();
    fault_in = 8'h00;
    repeat (5) tick();
    chk(grp_b_n === 1'b0, "R2 bit7 latched", {7'd0, grp_b_n}, 8'h00);
    strobe();
    chk(grp_b_n === 1'b0, "R9 capture without read keeps bit7", {7'd0, grp_b_n}, 8'h00);

    // ignored writes
    mode_sel = 2'b11; cs_n = 0; wr_n = 0; rd_n = 0; bus_in = 8'h85; tick(); idle_bus();
    cfg_write(8'h05);
    mode_sel = 2'b01; cs_n = 0; wr_n = 0; rd_n = 1; bus_in = 8'h90; tick(); idle_bus();
    mode_sel = 2'b10; cs_n = 0; rd_n = 0; wr_n = 1;
    #1 chk(bus_out === 8'h00, "R4 read outside config mode", bus_out, 8'h00);
    tick(); idle_bus();
    cfg_read(v);
    chk(v === 8'h80, "R5 ignored writes keep address", v, 8'h80);
    cfg_write(8'h81);
    cfg_read(v);
    chk(v === 8'h00, "R5 other address reads zero", v, 8'h00);
    cfg_write(8'hFF);
    cfg_read(v);
    chk(v === 8'h80, "R5 fault address restored", v, 8'h80);

    mode_sel = 2'b00;
    repeat (3) tick();
    done = 1;
    summary();
    $finish;
  end
endmodule